// File: doc/BRIEF.md
# Buck Switch PWM Timing Generator

This block turns a system clock into the switch timing for one synchronous buck stage. A free-running period counter divides the clock into switching periods of `PERIOD` clocks, which is 100 clocks at the default setting (1 MHz from a 100 MHz clock). Each period opens with the high-side switch. The high-side on-time ends at the first of three events: the latched duty command, the hard duty ceiling, or an over-current flag. The low-side switch then conducts until shortly before the next period, with a fixed dead interval between the two switches on every transition.

The duty command is sampled only at a period boundary, so a command that changes mid-period never disturbs the period in progress. The over-current comparator is asynchronous. It passes through a synchroniser. Once it is seen, the high side stays cut for the rest of that period and resumes normally at the next one. A high-impedance request forces both controls off without stopping the time base. Dropping enable parks both controls and the counter. A one-clock strobe marks the first drive cycle of every period.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: While reset is asserted, and until enable is first raised, `hs_o`, `ls_o` and `prd_stb_o` are all 0.
- R2: With enable held, the count runs 0 to PERIOD-1 and wraps. `prd_stb_o` is 1 for exactly one clock per period: the clock after count 0, which is output-cycle position 1.
- R3: Numbering the output cycles of a period 0 to PERIOD-1, `hs_o` is 1 in positions 1 to N and 0 elsewhere. N = min(duty, MAX_ON) is the duty value latched for that period.
- R4: A duty command of MAX_ON (98) or more yields exactly MAX_ON high-side cycles. Position 0 and position PERIOD-1 always keep the high side off.
- R5: For N > 0, `ls_o` is 1 in positions N+3 to PERIOD-2. For N = 0 it is 1 in positions 1 to PERIOD-2. `hs_o` and `ls_o` are never both 1. Each of them rises only after the other has been 0 for at least DEAD (2) clocks.
- R6: `ilim_i` passes through two synchroniser flops. Suppose it is sampled high at the clock edge that ends the cycle at count k. Then `hs_o` is 0 from position k+3 to the end of that period. The low side follows at k+5 under R5. The next period is unaffected.
- R7: A 1 on `hiz_i` makes both `hs_o` and `ls_o` 0 in the following cycle. The period counter keeps running, so the drive resumes at its normal position once `hiz_i` returns to 0.
- R8: A 0 on `en_i` makes both drives and the strobe 0 in the following cycle and holds the count at 0. The first cycle with `en_i` high is count 0 of a fresh period.
- R9: `duty_i` is latched only at the edge that ends count PERIOD-1, or at any edge while disabled. Values driven at other times have no effect on the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Regulator enable |
| hiz_i | input | 1 | Force both switch controls off |
| duty_i | input | DUTY_W (7) | High-side on-time command in clocks |
| ilim_i | input | 1 | Asynchronous over-current comparator flag |
| hs_o | output | 1 | High-side switch control |
| ls_o | output | 1 | Low-side switch control |
| prd_stb_o | output | 1 | One-clock period strobe |

## Verification
Both drives and the strobe are registered, so each follows the count and the inputs of the previous cycle by one clock. The over-current flag adds its two synchroniser stages, so a flag sampled at the end of count k reaches `hs_o` three positions later. A duty command applies from the period after the boundary that latched it. The bench drives inputs just after the falling edge and checks outputs at the next falling edge. After each drive it computes the expected values for the following cycle from the requirement formulas, so every comparison falls exactly where these latencies place the result. The duty sweep covers every command value from 0 to 127. The over-current cases bracket the point where the cut stops mattering (k = N-3 against k = N-2).

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  typedef struct packed {
    logic hs;
    logic ls;
  } drive_t;

  localparam drive_t DRIVE_OFF = '{hs: 1'b0, ls: 1'b0};

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];

endmodule

// File: rtl/pwm_flag_sync.sv
module pwm_flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic flag_o
);

  logic [STAGES-1:0] stg_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= flag_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], flag_i};
    end
  end

  assign flag_o = stg_q[STAGES-1];

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int PERIOD = 100,
  parameter int DUTY_W = 7,
  parameter int MAX_ON = 98,
  parameter int CNT_W  = 7,
  parameter int VW     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [VW-1:0]     lim_o,
  output logic              wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [VW-1:0]    lim_q, lim_d;
  logic             wrap, restart;

  always_comb begin
    wrap    = (cnt_q == CNT_W'(PERIOD - 1));
    restart = !en_i || wrap;
    cnt_d   = restart ? '0 : cnt_q + CNT_W'(1);
    lim_d   = (VW'(duty_i) > VW'(MAX_ON)) ? VW'(MAX_ON) : VW'(duty_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // duty is only taken at a period boundary or while parked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lim_q <= '0;
    else if (restart) lim_q <= lim_d;
  end

  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
  assign wrap_o = wrap;

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(PERIOD));
  assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt_q == CNT_W'(PERIOD - 1)) |=> (cnt_q == '0));
  assert_lim_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lim_q <= VW'(MAX_ON));
  assert_park_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_drive_seq.sv
module pwm_drive_seq
  import pwm_gate_pkg::*;
#(
  parameter int PERIOD = 100,
  parameter int MAX_ON = 98,
  parameter int DEAD   = 2,
  parameter int CNT_W  = 7,
  parameter int VW     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             hiz_i,
  input  logic             ilim_s_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [VW-1:0]    lim_i,
  input  logic             wrap_i,
  output logic             hs_o,
  output logic             ls_o,
  output logic             stb_o
);

  localparam int GW = $clog2(DEAD + 1);
  localparam int RW = CNT_W + 1;

  logic          cut_q, cut_d, cut_now;
  logic [GW-1:0] gap_q, gap_d;
  logic          hs_req, ls_req;
  drive_t        drv_q, drv_d;
  logic          stb_q, stb_d;

  always_comb begin
    cut_now = cut_q | ilim_s_i;
    hs_req  = en_i && (VW'(cnt_i) < lim_i) && !cut_now;
    ls_req  = en_i && !hs_req &&
              (VW'(cnt_i) < VW'(PERIOD - DEAD)) &&
              (gap_q >= GW'(DEAD));
    gap_d   = hs_req ? '0 :
              ((gap_q == GW'(DEAD)) ? gap_q : gap_q + GW'(1));
    cut_d   = (!en_i || wrap_i) ? 1'b0 : cut_now;
    drv_d   = hiz_i ? DRIVE_OFF : '{hs: hs_req, ls: ls_req};
    stb_d   = en_i && (cnt_i == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cut_q <= 1'b0;
      gap_q <= '0;
      drv_q <= DRIVE_OFF;
      stb_q <= 1'b0;
    end else begin
      cut_q <= cut_d;
      gap_q <= gap_d;
      drv_q <= drv_d;
      stb_q <= stb_d;
    end
  end

  assign hs_o  = drv_q.hs;
  assign ls_o  = drv_q.ls;
  assign stb_o = stb_q;

  // checker state: how long each side has been off, and the high-side run
  logic [GW-1:0] hs_off_q, ls_off_q;
  logic [RW-1:0] hs_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_off_q <= '0;
      ls_off_q <= '0;
      hs_run_q <= '0;
    end else begin
      hs_off_q <= drv_q.hs ? '0 : ((hs_off_q == GW'(DEAD)) ? hs_off_q : hs_off_q + GW'(1));
      ls_off_q <= drv_q.ls ? '0 : ((ls_off_q == GW'(DEAD)) ? ls_off_q : ls_off_q + GW'(1));
      hs_run_q <= drv_q.hs ? hs_run_q + RW'(1) : '0;
    end
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_q.hs && drv_q.ls));
  assert_ls_dead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q.ls) |-> (hs_off_q >= GW'(DEAD)));
  assert_hs_dead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q.hs) |-> (ls_off_q >= GW'(DEAD)));
  assert_on_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_run_q <= RW'(MAX_ON));
  assert_ilim_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_s_i |=> !drv_q.hs);
  assert_hiz_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_i |=> (!drv_q.hs && !drv_q.ls));
  assert_park_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!drv_q.hs && !drv_q.ls && !stb_q));

endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl
  import pwm_gate_pkg::*;
#(
  parameter int PERIOD      = 100,
  parameter int DUTY_W      = 7,
  parameter int MAX_ON      = 98,
  parameter int DEAD        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              hiz_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              ilim_i,
  output logic              hs_o,
  output logic              ls_o,
  output logic              prd_stb_o
);

  localparam int CNT_W = $clog2(PERIOD);
  localparam int VW    = (CNT_W > DUTY_W) ? CNT_W : DUTY_W;

  logic             rst_sync_n;
  logic             ilim_s;
  logic [CNT_W-1:0] cnt;
  logic [VW-1:0]    lim;
  logic             wrap;

  pwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_flag_sync #(.STAGES(SYNC_STAGES)) u_ilim_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .flag_i (ilim_i),
    .flag_o (ilim_s)
  );

  pwm_timebase #(
    .PERIOD (PERIOD),
    .DUTY_W (DUTY_W),
    .MAX_ON (MAX_ON),
    .CNT_W  (CNT_W),
    .VW     (VW)
  ) u_tb (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en_i   (en_i),
    .duty_i (duty_i),
    .cnt_o  (cnt),
    .lim_o  (lim),
    .wrap_o (wrap)
  );

  pwm_drive_seq #(
    .PERIOD (PERIOD),
    .MAX_ON (MAX_ON),
    .DEAD   (DEAD),
    .CNT_W  (CNT_W),
    .VW     (VW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (en_i),
    .hiz_i    (hiz_i),
    .ilim_s_i (ilim_s),
    .cnt_i    (cnt),
    .lim_i    (lim),
    .wrap_i   (wrap),
    .hs_o     (hs_o),
    .ls_o     (ls_o),
    .stb_o    (prd_stb_o)
  );

endmodule

// File: tb/tb_pwm_gate_ctrl.sv
module tb_pwm_gate_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_i = 1'b0;
  logic       hiz_i = 1'b0;
  logic [6:0] duty_i = '0;
  logic       ilim_i = 1'b0;
  logic       hs_o, ls_o, prd_stb_o;

  pwm_gate_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .hiz_i     (hiz_i),
    .duty_i    (duty_i),
    .ilim_i    (ilim_i),
    .hs_o      (hs_o),
    .ls_o      (ls_o),
    .prd_stb_o (prd_stb_o)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model: count of the current cycle, latched limit, cut position
  int   m_c = 0;
  int   m_lim = 0;
  int   m_cut = 1000;
  logic m_hs = 1'b0, m_ls = 1'b0, m_stb = 1'b0;
  logic h1 = 1'b0, h2 = 1'b0, l1 = 1'b0, l2 = 1'b0;

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at t=%0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  task automatic tick(input logic e, input logic z, input int d, input logic o, input string tag);
    int   eff;
    logic hr, lr;
    @(negedge clk);
    check(hs_o, m_hs, tag, "hs_o");
    check(ls_o, m_ls, tag, "ls_o");
    check(prd_stb_o, m_stb, "R2", "prd_stb_o");
    if (ls_o && !l1) check(h1 | h2, 1'b0, "R5", "high side off before ls rise");
    if (hs_o && !h1) check(l1 | l2, 1'b0, "R5", "low side off before hs rise");
    h2 = h1; h1 = hs_o; l2 = l1; l1 = ls_o;
    en_i = e; hiz_i = z; duty_i = 7'(d); ilim_i = o;
    if (e && o && (m_c + 2 < m_cut)) m_cut = m_c + 2;
    eff = (m_lim < m_cut) ? m_lim : m_cut;
    hr = e && (m_c < eff);
    lr = e && !hr && (m_c < 98) && ((eff == 0) || (m_c >= eff + 2));
    m_hs  = hr && !z;
    m_ls  = lr && !z;
    m_stb = e && (m_c == 0);
    if (!e || m_c == 99) begin
      m_lim = (d > 98) ? 98 : d;
      m_cut = 1000;
      m_c   = 0;
    end else begin
      m_c++;
    end
  endtask

  task automatic run_period(input int d, input int ok, input int za, input int zb, input string tag);
    for (int i = 0; i < 100; i++)
      tick(1'b1, (m_c >= za) && (m_c <= zb), d, m_c == ok, tag);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    rst_n = 1'b0;
    // R1: outputs low while reset is held and after release, before enable
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 0, 1'b0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 30, 1'b0, "R1");

    // R3 / R4: every duty command; each takes effect the period after it is driven
    run_period(0, -1, 1000, 1000, "R5");
    for (int d = 0; d < 128; d++)
      run_period(d, -1, 1000, 1000, (d >= 98) ? "R4" : "R3");
    run_period(0, -1, 1000, 1000, "R4");
    run_period(0, -1, 1000, 1000, "R5");

    // R9: duty toggles mid-period, only the value at the boundary counts
    for (int i = 0; i < 100; i++)
      tick(1'b1, 1'b0, (m_c == 99) ? 40 : ((m_c % 2 == 1) ? 20 : 80), 1'b0, "R9");
    run_period(40, -1, 1000, 1000, "R9");
    run_period(60, -1, 1000, 1000, "R9");

    // R6: over-current pulses at several counts with duty 60
    foreach (int_k_list[j]) begin
      run_period(60, int_k_list[j], 1000, 1000, "R6");
      run_period(60, -1, 1000, 1000, "R6");
    end

    // R7: high-impedance inside a period and across a boundary
    run_period(40, -1, 10, 60, "R7");
    run_period(40, -1, 95, 99, "R7");
    run_period(40, -1, 0, 3, "R7");
    run_period(40, -1, 1000, 1000, "R7");

    // R8: enable dropped mid on-time, then restarted
    for (int i = 0; i < 30; i++) tick(1'b1, 1'b0, 40, 1'b0, "R8");
    for (int i = 0; i < 7; i++) tick(1'b0, 1'b0, 70, 1'b0, "R8");
    run_period(70, -1, 1000, 1000, "R8");
    run_period(70, -1, 1000, 1000, "R8");
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 0, 1'b0, "R8");

    done = 1'b1;
    summary();
    $finish;
  end

  int int_k_list [6] = '{0, 5, 20, 55, 57, 58};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule